// File: doc/BRIEF.md
# Microword Control Decoder

This block sits between a registered 24-bit microinstruction and the datapath of a small byte-wide processor. It turns the middle and lower microword bytes into one write strobe per destination. It also selects what drives the data bus, forms a 16-bit memory address from one of four addressing modes, and raises the program-counter increment. The upper byte carries the ALU operation. That byte is decoded elsewhere and has no effect here.

Register-file operands live in their own small address area, which is flagged by a separate select output. The register number comes from constant bits in the microword. A bank flip-flop adds one address bit, but only for the upper set of registers. Pulsing the exchange input swaps that upper set with its alternate. Writing the high program-counter byte also loads the low byte from DPH in the same step. The flag-update enables and the condition-flag write are passed through from the microword.

Top module: `uword_decoder`

## Requirements
- R1: The destination code in microword bits [14:12] sets exactly one bit of `dstWr`, at the position equal to the code. The codes are 0 register T, 1 DPH, 2 DPL, 3 memory, 4 register A, 5 PCH, 6 video RAM, 7 output port. The memory and video strobes double as write enables for `memAddr`.
- R2: `wrPcl` is high in exactly the steps where destination code 5 (PCH) is selected. In those steps PCL is loaded from DPH.
- R3: For destination codes 3, 6 and 7, source bit [15] = 0 puts the lower microword byte [7:0] on `dataBus` as a literal, and [15] = 1 puts the operand bus there.
- R4: For the other destinations, source bit [15] = 0 puts an address byte on `dataBus`: the high byte when bit [3] is 1 and the low byte when it is 0. Source bit [15] = 1 puts `memRdData` there.
- R5: Mode bits [9:8] pick the address. 0 is the register area. 1 is zero page, giving {0x00, DPL}. 2 is the program counter. 3 is {DPH, DPL}.
- R6: In mode 0, `regSpace` is 1 and `memAddr` is {0x00, 2'b00, bank, bit[10], bit[3], bits[2:0]}. In every other mode `regSpace` is 0.
- R7: The bank bit is used only when bit [3] is 1. The bank flip-flop toggles on each clock edge that sees `bankXchg` high, holds otherwise, and clears on reset.
- R8: `pcInc` is 1 only in mode 2 when the address is used. That means a write to destination 3 or 6, or a memory read (bit [15] = 1 with a destination other than 3, 6 or 7). It stays 0 when the PC is only read as an address byte.
- R9: `operandBus` carries register A when bit [7] is 1 and register T when it is 0.
- R10: `updC`, `updZ` and `updN` follow bits [6], [5] and [4], and `wrFlagF` follows bit [11].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| uWord | input | 24 | Registered microinstruction |
| pcVal | input | 16 | Program counter |
| dphVal | input | 8 | Data pointer high byte |
| dplVal | input | 8 | Data pointer low byte |
| regA | input | 8 | Register A |
| regT | input | 8 | Register T |
| memRdData | input | 8 | Read data from the addressed memory |
| bankXchg | input | 1 | Toggle the register bank flip-flop |
| dstWr | output | 8 | One-hot destination write strobes |
| wrPcl | output | 1 | Load PCL from DPH (with PCH write) |
| memAddr | output | 16 | Decoded memory address |
| regSpace | output | 1 | Address targets the register area |
| pcInc | output | 1 | Increment program counter |
| dataBus | output | 8 | Data bus value |
| operandBus | output | 8 | Operand bus value |
| updC | output | 1 | Carry flag update enable |
| updZ | output | 1 | Zero flag update enable |
| updN | output | 1 | Negative flag update enable |
| wrFlagF | output | 1 | Condition flag write enable |

## Verification
Every strobe, address, bus value and enable is combinational in the microword and the register inputs. These results are due in the same cycle the stimulus is applied. The bench drives each vector on the falling edge and samples 2 ns later, before the next rising edge. The bank bit is the only registered result. It shows in the address one rising edge after the cycle that held `bankXchg` high, so the bench drops the pulse and then checks the address on the following falling edge.

// File: rtl/uword_pkg.sv
package uword_pkg;
  localparam int DW       = 8;
  localparam int AW       = 2 * DW;
  localparam int UW       = 3 * DW;
  localparam int DEST_N   = 8;
  localparam int DEST_W   = $clog2(DEST_N);
  localparam int REGIDX_W = 4;

  // microword bit positions (consumed by neighbouring logic, fixed)
  localparam int B_SRC   = 15;
  localparam int B_DSTLO = 12;
  localparam int B_WRF   = 11;
  localparam int B_REG3  = 10;
  localparam int B_MODE  = 8;
  localparam int B_ACCA  = 7;
  localparam int B_UPDC  = 6;
  localparam int B_UPDZ  = 5;
  localparam int B_UPDN  = 4;
  localparam int B_HI    = 3;

  typedef enum logic [DEST_W-1:0] {
    DST_T = 3'd0, DST_DPH = 3'd1, DST_DPL = 3'd2, DST_MEM = 3'd3,
    DST_A = 3'd4, DST_PCH = 3'd5, DST_VID = 3'd6, DST_PORT = 3'd7
  } destCode_e;

  typedef enum logic [1:0] {
    AM_REG = 2'd0, AM_ZPG = 2'd1, AM_PC = 2'd2, AM_FULL = 2'd3
  } addrMode_e;

  typedef enum logic [1:0] {
    BS_LIT = 2'd0, BS_OPER = 2'd1, BS_ADDR = 2'd2, BS_MEM = 2'd3
  } busSel_e;

  typedef struct packed {
    busSel_e               busSel;
    addrMode_e             addrMode;
    logic                  accA;
    logic                  hi;
    logic [REGIDX_W-1:0]   regIdx;
    logic [DW-1:0]         literal;
  } pathCtl_t;
endpackage

// File: rtl/uword_ctrl.sv
module uword_ctrl
  import uword_pkg::*;
(
  input  logic [UW-1:0]     uWord,
  output pathCtl_t          pathCtl,
  output logic [DEST_N-1:0] dstWr,
  output logic              wrPcl,
  output logic              pcInc,
  output logic              updC,
  output logic              updZ,
  output logic              updN,
  output logic              wrFlagF
);
  logic       unusedAluByte;
  destCode_e  dest;
  addrMode_e  mode;
  logic       srcBit;
  logic       outDest;
  logic       storeDest;
  logic       addrUsed;

  assign unusedAluByte = ^uWord[UW-1:AW];

  assign dest   = destCode_e'(uWord[B_DSTLO +: DEST_W]);
  assign mode   = addrMode_e'(uWord[B_MODE +: 2]);
  assign srcBit = uWord[B_SRC];

  // destinations whose bus value is outbound (literal or operand)
  assign storeDest = (dest == DST_MEM) || (dest == DST_VID);
  assign outDest   = storeDest || (dest == DST_PORT);

  // one strobe per destination code
  for (genvar d = 0; d < DEST_N; d++) begin : g_dest
    assign dstWr[d] = (dest == destCode_e'(d));
  end

  assign wrPcl = (dest == DST_PCH);

  // the address is consumed by a store or by a memory read
  assign addrUsed = storeDest || (!outDest && srcBit);
  assign pcInc    = addrUsed && (mode == AM_PC);

  always_comb begin
    pathCtl.addrMode = mode;
    pathCtl.accA     = uWord[B_ACCA];
    pathCtl.hi       = uWord[B_HI];
    pathCtl.regIdx   = {uWord[B_REG3], uWord[REGIDX_W-2:0]};
    pathCtl.literal  = uWord[DW-1:0];
    if (outDest) pathCtl.busSel = srcBit ? BS_OPER : BS_LIT;
    else         pathCtl.busSel = srcBit ? BS_MEM  : BS_ADDR;
  end

  assign updC    = uWord[B_UPDC];
  assign updZ    = uWord[B_UPDZ];
  assign updN    = uWord[B_UPDN];
  assign wrFlagF = uWord[B_WRF];
endmodule

// File: rtl/uword_datapath.sv
module uword_datapath
  import uword_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  pathCtl_t      pathCtl,
  input  logic [AW-1:0] pcVal,
  input  logic [DW-1:0] dphVal,
  input  logic [DW-1:0] dplVal,
  input  logic [DW-1:0] regA,
  input  logic [DW-1:0] regT,
  input  logic [DW-1:0] memRdData,
  input  logic          bankXchg,
  output logic [AW-1:0] memAddr,
  output logic          regSpace,
  output logic [DW-1:0] dataBus,
  output logic [DW-1:0] operandBus,
  output logic          bankState
);
  localparam int REG_PAD = DW - REGIDX_W - 2;

  logic          bankQ;
  logic          bankBit;
  logic [DW-1:0] regLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         bankQ <= 1'b0;
    else if (bankXchg) bankQ <= ~bankQ;
  end
  assign bankState = bankQ;

  // bank bit only reaches the upper register set
  assign bankBit = pathCtl.hi & bankQ;
  assign regLow  = {{REG_PAD{1'b0}}, bankBit, pathCtl.regIdx[REGIDX_W-1],
                    pathCtl.hi, pathCtl.regIdx[REGIDX_W-2:0]};

  always_comb begin
    unique case (pathCtl.addrMode)
      AM_REG:  memAddr = {{DW{1'b0}}, regLow};
      AM_ZPG:  memAddr = {{DW{1'b0}}, dplVal};
      AM_PC:   memAddr = pcVal;
      default: memAddr = {dphVal, dplVal};
    endcase
  end
  assign regSpace = (pathCtl.addrMode == AM_REG);

  assign operandBus = pathCtl.accA ? regA : regT;

  always_comb begin
    unique case (pathCtl.busSel)
      BS_LIT:  dataBus = pathCtl.literal;
      BS_OPER: dataBus = operandBus;
      BS_ADDR: dataBus = pathCtl.hi ? memAddr[AW-1:DW] : memAddr[DW-1:0];
      default: dataBus = memRdData;
    endcase
  end
endmodule

// File: rtl/uword_decoder.sv
module uword_decoder
  import uword_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [UW-1:0]     uWord,
  input  logic [AW-1:0]     pcVal,
  input  logic [DW-1:0]     dphVal,
  input  logic [DW-1:0]     dplVal,
  input  logic [DW-1:0]     regA,
  input  logic [DW-1:0]     regT,
  input  logic [DW-1:0]     memRdData,
  input  logic              bankXchg,
  output logic [DEST_N-1:0] dstWr,
  output logic              wrPcl,
  output logic [AW-1:0]     memAddr,
  output logic              regSpace,
  output logic              pcInc,
  output logic [DW-1:0]     dataBus,
  output logic [DW-1:0]     operandBus,
  output logic              updC,
  output logic              updZ,
  output logic              updN,
  output logic              wrFlagF
);
  pathCtl_t pathCtl;
  logic     bankState;

  uword_ctrl u_ctrl (
    .uWord   (uWord),
    .pathCtl (pathCtl),
    .dstWr   (dstWr),
    .wrPcl   (wrPcl),
    .pcInc   (pcInc),
    .updC    (updC),
    .updZ    (updZ),
    .updN    (updN),
    .wrFlagF (wrFlagF)
  );

  uword_datapath u_path (
    .clk        (clk),
    .rstN       (rstN),
    .pathCtl    (pathCtl),
    .pcVal      (pcVal),
    .dphVal     (dphVal),
    .dplVal     (dplVal),
    .regA       (regA),
    .regT       (regT),
    .memRdData  (memRdData),
    .bankXchg   (bankXchg),
    .memAddr    (memAddr),
    .regSpace   (regSpace),
    .dataBus    (dataBus),
    .operandBus (operandBus),
    .bankState  (bankState)
  );
endmodule

// File: rtl/uword_decoder_checker.sv
module uword_decoder_checker
  import uword_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [UW-1:0]     uWord,
  input logic [AW-1:0]     pcVal,
  input logic [DW-1:0]     regA,
  input logic [DW-1:0]     regT,
  input logic              bankXchg,
  input logic [DEST_N-1:0] dstWr,
  input logic              wrPcl,
  input logic [AW-1:0]     memAddr,
  input logic              regSpace,
  input logic              pcInc,
  input logic [DW-1:0]     operandBus,
  input logic              bankState
);
  assert_onehot_dest_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(dstWr) == 1);

  assert_pcl_with_pch_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrPcl |-> dstWr[DST_PCH]);

  assert_regspace_page_R6: assert property (@(posedge clk) disable iff (!rstN)
    regSpace |-> (memAddr[AW-1:DW] == '0));

  assert_bank_toggle_R7: assert property (@(posedge clk) disable iff (!rstN)
    bankXchg |=> (bankState != $past(bankState)));

  assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !bankXchg |=> $stable(bankState));

  assert_pcinc_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    pcInc |-> (memAddr == pcVal) && !regSpace);

  assert_operand_sel_R9: assert property (@(posedge clk) disable iff (!rstN)
    operandBus == (uWord[B_ACCA] ? regA : regT));
endmodule

bind uword_decoder uword_decoder_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .uWord      (uWord),
  .pcVal      (pcVal),
  .regA       (regA),
  .regT       (regT),
  .bankXchg   (bankXchg),
  .dstWr      (dstWr),
  .wrPcl      (wrPcl),
  .memAddr    (memAddr),
  .regSpace   (regSpace),
  .pcInc      (pcInc),
  .operandBus (operandBus),
  .bankState  (bankState)
);

// File: tb/uword_decoder_bench.sv
module uword_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [23:0] uWord;
  logic [15:0] pcVal;
  logic [7:0]  dphVal, dplVal, regA, regT, memRdData;
  logic        bankXchg;
  logic [7:0]  dstWr;
  logic        wrPcl, regSpace, pcInc, updC, updZ, updN, wrFlagF;
  logic [15:0] memAddr;
  logic [7:0]  dataBus, operandBus;

  int total = 0;
  int bad   = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  uword_decoder u_uword_decoder (
    .clk(clk), .rstN(rstN), .uWord(uWord), .pcVal(pcVal), .dphVal(dphVal),
    .dplVal(dplVal), .regA(regA), .regT(regT), .memRdData(memRdData),
    .bankXchg(bankXchg), .dstWr(dstWr), .wrPcl(wrPcl), .memAddr(memAddr),
    .regSpace(regSpace), .pcInc(pcInc), .dataBus(dataBus),
    .operandBus(operandBus), .updC(updC), .updZ(updZ), .updN(updN),
    .wrFlagF(wrFlagF)
  );

  typedef struct packed {
    logic [23:0] uw;
    logic [15:0] addr;
    logic [7:0]  bus;
    logic [7:0]  dst;
    logic        inc;
    logic        rsp;
    logic [3:0]  flg;   // {wrFlagF, updC, updZ, updN}
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{24'hFF8200, 16'h1234, 8'h77, 8'h01, 1'b1, 1'b0, 4'b0000}, // T <- mem(pc), ALU byte ignored
    '{24'h002308, 16'hABCD, 8'hAB, 8'h04, 1'b0, 1'b0, 4'b0000}, // DPL <- addr hi, full
    '{24'h001200, 16'h1234, 8'h34, 8'h02, 1'b0, 1'b0, 4'b0000}, // DPH <- pc low, no inc
    '{24'h00315E, 16'h00CD, 8'h5E, 8'h08, 1'b0, 1'b0, 4'b0101}, // mem <- literal, zero page
    '{24'h00B280, 16'h1234, 8'h5A, 8'h08, 1'b1, 1'b0, 4'b0000}, // mem(pc) <- A
    '{24'h00C405, 16'h0015, 8'h77, 8'h10, 1'b0, 1'b1, 4'b0000}, // A <- reg 0x15
    '{24'h00D370, 16'hABCD, 8'h77, 8'h20, 1'b0, 1'b0, 4'b0111}, // PCH <- mem(full)
    '{24'h00E200, 16'h1234, 8'hC3, 8'h40, 1'b1, 1'b0, 4'b0000}, // video(pc) <- T
    '{24'h007A3C, 16'h1234, 8'h3C, 8'h80, 1'b0, 1'b0, 4'b1011}, // port <- literal
    '{24'h00000B, 16'h000B, 8'h00, 8'h01, 1'b0, 1'b1, 4'b0000}  // T <- addr hi, upper reg
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic applyAt(input logic [23:0] uw);
    @(negedge clk);
    uWord = uw;
    #2;
  endtask

  task automatic pulseBank();
    @(negedge clk);
    bankXchg = 1'b1;
    @(negedge clk);
    bankXchg = 1'b0;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; uWord = 24'h000000; bankXchg = 1'b0;
    pcVal = 16'h1234; dphVal = 8'hAB; dplVal = 8'hCD;
    regA = 8'h5A; regT = 8'hC3; memRdData = 8'h77;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state: bank cleared, upper register 0x0B not moved
    applyAt(24'h00000B);
    check("R7 reset bank clear addr", memAddr, 16'h000B);
    check("R6 reset regSpace", regSpace, 1);

    for (int i = 0; i < NV; i++) begin
      applyAt(VECS[i].uw);
      check("R1 dest strobes", dstWr, VECS[i].dst);
      check("R2 pcl with pch", wrPcl, VECS[i].dst == 8'h20);
      check("R3/R4 data bus", dataBus, VECS[i].bus);
      check("R5 address", memAddr, VECS[i].addr);
      check("R6 regSpace", regSpace, VECS[i].rsp);
      check("R8 pc increment", pcInc, VECS[i].inc);
      check("R9 operand bus", operandBus, VECS[i].uw[7] ? 8'h5A : 8'hC3);
      check("R10 flag enables", {wrFlagF, updC, updZ, updN}, VECS[i].flg);
    end

    // R7: toggle bank, upper register moves to bank 1
    pulseBank();
    applyAt(24'h00000B);
    check("R7 bank1 upper reg", memAddr, 16'h002B);
    // R7: lower register unaffected by bank
    applyAt(24'h00C405);
    check("R7 bank1 lower reg", memAddr, 16'h0015);
    // R7: no pulse, bank holds
    repeat (2) @(negedge clk);
    applyAt(24'h00000B);
    check("R7 bank hold", memAddr, 16'h002B);
    // R7: toggle back
    pulseBank();
    applyAt(24'h00000B);
    check("R7 bank toggle back", memAddr, 16'h000B);
    // R7: reset clears a set bank
    pulseBank();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    applyAt(24'h00000B);
    check("R7 reset clears bank", memAddr, 16'h000B);

    // R8: register-mode read with SRC=1 does not increment
    applyAt(24'h00C405);
    check("R8 no inc in reg mode", pcInc, 0);
    // R8: pc low read as address byte (SRC=0) does not increment
    applyAt(24'h001200);
    check("R8 no inc on pc source", pcInc, 0);
    // R4: low address byte in zero page with HI=0
    applyAt(24'h001100);
    check("R4 zero page low byte", dataBus, 8'hCD);
    // R9: operand switches with A while T fixed
    regA = 8'h11;
    applyAt(24'h00B280);
    check("R9 operand follows A", dataBus, 8'h11);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule